// File: doc/BRIEF.md
# Write-Update Snooping Cache Line Controller

This block is the coherence controller of one small direct-mapped cache on a shared, atomic snooping bus. It keeps each present line in one of four stable states: exclusive clean (`LS_EXCL`), shared clean (`LS_SHCLN`), shared owned-dirty (`LS_SHMOD`) and modified (`LS_MOD`). Copies held by other caches are never invalidated. A processor write to a shared line is instead broadcast as a one-word bus update that every other holder applies to its own copy. Only the cache in `LS_SHMOD` or `LS_MOD` owns dirty data. That cache supplies the whole line when another cache reads it, and it writes the line back when the line is evicted.

The processor side is a hold-until-acknowledge request: `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` stay constant until `cpu_ack` pulses. On the master side the controller raises `mst_req` with a command. In the single cycle in which `mst_gnt` is high, the environment returns the wired-OR shared line on `mst_shared` and, for a read, the line contents on `mst_fill`. On the snoop side, each cycle with `snp_valid` set is one foreign transaction. The controller answers it combinationally on `snp_shared`, `snp_supply` and `snp_block`, and applies the state or data change at the following clock edge. Bus command codes are 0 = line read, 1 = word update, 2 = write-back. A word address splits, from the most significant bit down, into tag, set index and word offset. Word k of a line occupies bits [k*WORD_W +: WORD_W] of a block.

Control sequencer states: `CS_IDLE` (look up the request), `CS_WBACK` (evict an owned victim), `CS_FILL` (line read), `CS_UPD` (word update), `CS_RESP` (acknowledge). Its transitions are:
- `CS_IDLE` goes to `CS_RESP` on a read hit, or on a write hit in `LS_EXCL` or `LS_MOD`.
- `CS_IDLE` goes to `CS_UPD` on a write hit in a shared state.
- `CS_IDLE` goes to `CS_WBACK` on a miss whose victim is owned, and to `CS_FILL` on any other miss.
- `CS_WBACK` goes to `CS_FILL` on grant.
- `CS_FILL` goes to `CS_UPD` on grant for a write when shared is asserted, and to `CS_RESP` otherwise.
- `CS_UPD` goes to `CS_RESP` on grant.
- `CS_RESP` returns to `CS_IDLE`.

Line state transitions are:
- A fill leaves the line in `LS_EXCL`/`LS_SHCLN` after a read, and in `LS_MOD`/`LS_SHMOD` after a write, chosen by the shared line.
- A local write moves `LS_EXCL` to `LS_MOD`.
- A granted update moves the line to `LS_SHMOD` if shared was asserted and to `LS_MOD` if it was not.
- A snooped read moves an owner to `LS_SHMOD` and `LS_EXCL` to `LS_SHCLN`.
- A snooped update moves any state to `LS_SHCLN`.

Top module: `dragon_cache_ctrl`

## Requirements
- R1: After reset no line is present: a snooped read of any address leaves `snp_shared` and `snp_supply` low, and `cpu_ack` and `mst_req` are low.
- R2: A read miss issues one line read (command 0) at the line-aligned address. It returns word `cpu_addr` offset from `mst_fill`. The line becomes `LS_EXCL` when `mst_shared` was low at the grant and `LS_SHCLN` when it was high.
- R3: A read hit is acknowledged in the cycle after it is accepted, without any bus request, and returns the stored word.
- R4: A write hit in `LS_MOD` or `LS_EXCL` is done locally with no bus request. The line is then `LS_MOD`.
- R5: A write hit in `LS_SHCLN` or `LS_SHMOD` issues one update (command 1) carrying `cpu_addr` and `cpu_wdata`. The line then becomes `LS_SHMOD` if `mst_shared` was high at the grant, or `LS_MOD` if it was low.
- R6: While an update waits for its grant, the local copy of the line keeps its old contents.
- R7: A write miss issues a line read. If shared is asserted, the line loads as `LS_SHMOD` and an update with the written word follows. If shared is not asserted, the line loads as `LS_MOD` with the word merged in and no update is issued.
- R8: A snooped line read that hits asserts `snp_shared`. If the line is owned (`LS_SHMOD` or `LS_MOD`), the controller also asserts `snp_supply`, drives the line on `snp_block` and moves to `LS_SHMOD`. `LS_EXCL` becomes `LS_SHCLN`.
- R9: A snooped update that hits asserts `snp_shared`, does not supply, writes `snp_word` into the addressed word and leaves the line in `LS_SHCLN`.
- R10: A snooped transaction whose tag does not match the stored line has no effect on signals or contents.
- R11: A miss whose victim is owned first writes the victim back (command 2, victim address, victim contents) and then reads the new line. A clean victim is replaced without a write-back.
- R12: A processor request is not accepted in any cycle in which `snp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until acknowledged |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | WORD_W | Write word |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | WORD_W | Addressed word, valid with `cpu_ack` |
| mst_req | output | 1 | Bus request |
| mst_cmd | output | 2 | 0 read line, 1 update word, 2 write back, 3 none |
| mst_addr | output | ADDR_W | Transaction address (line-aligned for read and write-back) |
| mst_word | output | WORD_W | Word carried by an update |
| mst_block | output | BLK_W | Line carried by a write-back |
| mst_gnt | input | 1 | Single-cycle grant; the transaction completes in this cycle |
| mst_shared | input | 1 | Wired-OR shared line sampled at grant |
| mst_fill | input | BLK_W | Line returned for a read at grant |
| snp_valid | input | 1 | A foreign transaction is on the bus |
| snp_cmd | input | 2 | Foreign command, same encoding as `mst_cmd` |
| snp_addr | input | ADDR_W | Foreign address |
| snp_word | input | WORD_W | Foreign update word |
| snp_shared | output | 1 | This cache holds the snooped line |
| snp_supply | output | 1 | This cache provides the line in place of memory |
| snp_block | output | BLK_W | Supplied line, zero when not supplying |

## Verification
The hardest case to reach is R6: the gap between a write to a shared line and the grant of its update, during which the local copy must stay old. The bench holds back its bus grant for several cycles while the write waits. In that window it snoops a line read to the same line, so the owned copy is driven on `snp_block` and its old contents can be compared. Line states are never visible directly. Each one is inferred from what the next action reveals: whether a later write produces an update, whether a snooped read is supplied, and whether an eviction writes back.

// File: rtl/dragon_pkg.sv
package dragon_pkg;

    typedef enum logic [1:0] {
        LS_EXCL  = 2'd0,
        LS_SHCLN = 2'd1,
        LS_SHMOD = 2'd2,
        LS_MOD   = 2'd3
    } line_st_t;

    typedef enum logic [1:0] {
        BC_READ   = 2'd0,
        BC_UPDATE = 2'd1,
        BC_WBACK  = 2'd2,
        BC_NONE   = 2'd3
    } bus_cmd_t;

    typedef enum logic [2:0] {
        CS_IDLE,
        CS_WBACK,
        CS_FILL,
        CS_UPD,
        CS_RESP
    } ctl_st_t;

    function automatic logic is_owner(line_st_t s);
        return (s == LS_SHMOD) || (s == LS_MOD);
    endfunction

endpackage

// File: rtl/dragon_snoop.sv
module dragon_snoop
    import dragon_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       snp_valid,
    input  logic [1:0] snp_cmd,
    input  logic       line_vld,
    input  logic       tag_eq,
    input  line_st_t   cur_st,
    output logic       shared,
    output logic       supply,
    output logic       wr_word,
    output logic       set_st,
    output line_st_t   nxt_st
);

    logic hit;

    assign hit = snp_valid && line_vld && tag_eq &&
                 (snp_cmd == BC_READ || snp_cmd == BC_UPDATE);

    always_comb begin
        shared  = 1'b0;
        supply  = 1'b0;
        wr_word = 1'b0;
        set_st  = 1'b0;
        nxt_st  = cur_st;
        if (hit) begin
            shared = 1'b1;
            set_st = 1'b1;
            if (snp_cmd == BC_READ) begin
                supply = is_owner(cur_st);
                nxt_st = is_owner(cur_st) ? LS_SHMOD : LS_SHCLN;
            end else begin
                wr_word = 1'b1;
                nxt_st  = LS_SHCLN;
            end
        end
    end

    // R8: supplying data implies the line is held
    a_r8_supply_shared: assert property (@(posedge clk) disable iff (!rst_n)
        supply |-> shared);

    // R10: nothing is driven when no transaction is present
    a_r10_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !snp_valid |-> (!shared && !set_st));

endmodule

// File: rtl/dragon_ctrl.sv
module dragon_ctrl
    import dragon_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_req,
    input  logic       cpu_we,
    input  logic       lk_hit,
    input  line_st_t   lk_st,
    input  logic       victim_dirty,
    input  logic       snp_valid,
    input  logic       mst_gnt,
    input  logic       mst_shared,
    output ctl_st_t    st_o,
    output logic       mst_req,
    output logic [1:0] mst_cmd,
    output logic       cpu_ack,
    output logic       wr_local,
    output logic       fill_go,
    output logic       fill_wr,
    output line_st_t   fill_st,
    output logic       upd_go,
    output line_st_t   upd_st
);

    ctl_st_t st_q, st_d;
    logic    accept;

    assign accept = (st_q == CS_IDLE) && cpu_req && !snp_valid;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CS_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CS_IDLE: begin
                if (accept) begin
                    if (lk_hit) begin
                        if (!cpu_we || lk_st == LS_EXCL || lk_st == LS_MOD) st_d = CS_RESP;
                        else                                                st_d = CS_UPD;
                    end else if (victim_dirty) begin
                        st_d = CS_WBACK;
                    end else begin
                        st_d = CS_FILL;
                    end
                end
            end
            CS_WBACK: if (mst_gnt) st_d = CS_FILL;
            CS_FILL:  if (mst_gnt) st_d = (cpu_we && mst_shared) ? CS_UPD : CS_RESP;
            CS_UPD:   if (mst_gnt) st_d = CS_RESP;
            CS_RESP:  st_d = CS_IDLE;
            default:  st_d = CS_IDLE;
        endcase
    end

    always_comb begin
        mst_req  = 1'b0;
        mst_cmd  = BC_NONE;
        cpu_ack  = 1'b0;
        wr_local = 1'b0;
        fill_go  = 1'b0;
        upd_go   = 1'b0;
        fill_wr  = cpu_we && !mst_shared;
        fill_st  = cpu_we ? (mst_shared ? LS_SHMOD : LS_MOD)
                          : (mst_shared ? LS_SHCLN : LS_EXCL);
        upd_st   = mst_shared ? LS_SHMOD : LS_MOD;
        unique case (st_q)
            CS_IDLE:  wr_local = accept && lk_hit && cpu_we &&
                                 (lk_st == LS_EXCL || lk_st == LS_MOD);
            CS_WBACK: begin mst_req = 1'b1; mst_cmd = BC_WBACK; end
            CS_FILL:  begin mst_req = 1'b1; mst_cmd = BC_READ;   fill_go = mst_gnt; end
            CS_UPD:   begin mst_req = 1'b1; mst_cmd = BC_UPDATE; upd_go  = mst_gnt; end
            CS_RESP:  cpu_ack = 1'b1;
            default:  ;
        endcase
    end

    assign st_o = st_q;

    // R12: a foreign transaction stalls acceptance
    a_r12_snoop_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CS_IDLE && snp_valid) |=> (st_q == CS_IDLE));

    // R3: read hit acknowledged next cycle with no bus use
    a_r3_hit_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && lk_hit && !cpu_we) |=> (cpu_ack && !mst_req));

    // R5: a granted update completes the request
    a_r5_upd_then_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CS_UPD && mst_gnt) |=> cpu_ack);

endmodule

// File: rtl/dragon_cache_ctrl.sv
module dragon_cache_ctrl
    import dragon_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 16,
    parameter int SETS   = 4,
    parameter int WORDS  = 2,
    localparam int OFF_W = $clog2(WORDS),
    localparam int IDX_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W,
    localparam int BLK_W = WORD_W * WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic              cpu_ack,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              mst_req,
    output logic [1:0]        mst_cmd,
    output logic [ADDR_W-1:0] mst_addr,
    output logic [WORD_W-1:0] mst_word,
    output logic [BLK_W-1:0]  mst_block,
    input  logic              mst_gnt,
    input  logic              mst_shared,
    input  logic [BLK_W-1:0]  mst_fill,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [WORD_W-1:0] snp_word,
    output logic              snp_shared,
    output logic              snp_supply,
    output logic [BLK_W-1:0]  snp_block
);

    logic              vld_q [SETS];
    logic [TAG_W-1:0]  tag_q [SETS];
    line_st_t          st_q  [SETS];
    logic [BLK_W-1:0]  blk_q [SETS];

    logic [OFF_W-1:0]  cpu_off, snp_off;
    logic [IDX_W-1:0]  cpu_idx, snp_idx;
    logic [TAG_W-1:0]  cpu_tag, snp_tag;

    assign cpu_off = cpu_addr[OFF_W-1:0];
    assign cpu_idx = cpu_addr[OFF_W +: IDX_W];
    assign cpu_tag = cpu_addr[ADDR_W-1 -: TAG_W];
    assign snp_off = snp_addr[OFF_W-1:0];
    assign snp_idx = snp_addr[OFF_W +: IDX_W];
    assign snp_tag = snp_addr[ADDR_W-1 -: TAG_W];

    function automatic logic [BLK_W-1:0] put_word(input logic [BLK_W-1:0] b,
                                                  input logic [OFF_W-1:0] o,
                                                  input logic [WORD_W-1:0] w);
        logic [BLK_W-1:0] r;
        r = b;
        r[int'(o)*WORD_W +: WORD_W] = w;
        return r;
    endfunction

    logic [BLK_W-1:0] cur_blk;
    line_st_t         cur_st;
    logic             lk_hit, victim_dirty;

    assign cur_blk      = blk_q[cpu_idx];
    assign cur_st       = st_q[cpu_idx];
    assign lk_hit       = vld_q[cpu_idx] && (tag_q[cpu_idx] == cpu_tag);
    assign victim_dirty = vld_q[cpu_idx] && is_owner(cur_st);

    logic     sn_wr_word, sn_set_st;
    line_st_t sn_nxt;

    dragon_snoop u_snoop (
        .clk       (clk),
        .rst_n     (rst_n),
        .snp_valid (snp_valid),
        .snp_cmd   (snp_cmd),
        .line_vld  (vld_q[snp_idx]),
        .tag_eq    (tag_q[snp_idx] == snp_tag),
        .cur_st    (st_q[snp_idx]),
        .shared    (snp_shared),
        .supply    (snp_supply),
        .wr_word   (sn_wr_word),
        .set_st    (sn_set_st),
        .nxt_st    (sn_nxt)
    );

    ctl_st_t  ctl_st;
    logic     wr_local, fill_go, fill_wr, upd_go;
    line_st_t fill_st, upd_st;

    dragon_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .lk_hit       (lk_hit),
        .lk_st        (cur_st),
        .victim_dirty (victim_dirty),
        .snp_valid    (snp_valid),
        .mst_gnt      (mst_gnt),
        .mst_shared   (mst_shared),
        .st_o         (ctl_st),
        .mst_req      (mst_req),
        .mst_cmd      (mst_cmd),
        .cpu_ack      (cpu_ack),
        .wr_local     (wr_local),
        .fill_go      (fill_go),
        .fill_wr      (fill_wr),
        .fill_st      (fill_st),
        .upd_go       (upd_go),
        .upd_st       (upd_st)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) begin
                vld_q[i] <= 1'b0;
                tag_q[i] <= '0;
                st_q[i]  <= LS_EXCL;
                blk_q[i] <= '0;
            end
        end else begin
            if (sn_set_st)  st_q[snp_idx]  <= sn_nxt;
            if (sn_wr_word) blk_q[snp_idx] <= put_word(blk_q[snp_idx], snp_off, snp_word);
            if (wr_local) begin
                blk_q[cpu_idx] <= put_word(cur_blk, cpu_off, cpu_wdata);
                st_q[cpu_idx]  <= LS_MOD;
            end
            if (fill_go) begin
                vld_q[cpu_idx] <= 1'b1;
                tag_q[cpu_idx] <= cpu_tag;
                blk_q[cpu_idx] <= fill_wr ? put_word(mst_fill, cpu_off, cpu_wdata) : mst_fill;
                st_q[cpu_idx]  <= fill_st;
            end
            if (upd_go) begin
                blk_q[cpu_idx] <= put_word(cur_blk, cpu_off, cpu_wdata);
                st_q[cpu_idx]  <= upd_st;
            end
        end
    end

    always_comb begin
        unique case (ctl_st)
            CS_WBACK: mst_addr = {tag_q[cpu_idx], cpu_idx, {OFF_W{1'b0}}};
            CS_FILL:  mst_addr = {cpu_tag, cpu_idx, {OFF_W{1'b0}}};
            default:  mst_addr = cpu_addr;
        endcase
    end

    assign mst_word  = cpu_wdata;
    assign mst_block = cur_blk;
    assign cpu_rdata = cur_blk[int'(cpu_off)*WORD_W +: WORD_W];
    assign snp_block = snp_supply ? blk_q[snp_idx] : '0;

    // R11: only an owned victim is written back
    a_r11_wb_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_req && mst_cmd == BC_WBACK) |-> (vld_q[cpu_idx] && is_owner(cur_st)));

    // R6: local copy frozen while the update waits
    a_r6_local_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_st == CS_UPD && !mst_gnt && !snp_valid) |=> $stable(cur_blk));

    // R5: line state after a granted update follows the shared line
    a_r5_upd_state: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_st == CS_UPD && mst_gnt) |=> (cur_st == ($past(mst_shared) ? LS_SHMOD : LS_MOD)));

    // R2: read fill state follows the shared line
    a_r2_fill_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_st == CS_FILL && mst_gnt && !cpu_we) |=>
            (cur_st == ($past(mst_shared) ? LS_SHCLN : LS_EXCL)));

endmodule

// File: tb/dragon_cache_ctrl_test.sv
module dragon_cache_ctrl_test;

    localparam int P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_req, cpu_we;
    logic [7:0]  cpu_addr;
    logic [15:0] cpu_wdata;
    logic        cpu_ack;
    logic [15:0] cpu_rdata;
    logic        mst_req;
    logic [1:0]  mst_cmd;
    logic [7:0]  mst_addr;
    logic [15:0] mst_word;
    logic [31:0] mst_block;
    logic        mst_gnt = 1'b0;
    logic        mst_shared = 1'b0;
    logic [31:0] mst_fill = '0;
    logic        snp_valid;
    logic [1:0]  snp_cmd;
    logic [7:0]  snp_addr;
    logic [15:0] snp_word;
    logic        snp_shared, snp_supply;
    logic [31:0] snp_block;

    always #(P/2) clk = ~clk;

    dragon_cache_ctrl uut (.*);

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic        env_shared = 1'b0;
    logic [31:0] env_fill   = '0;
    logic        hold       = 1'b0;
    int          nlog       = 0;
    logic [1:0]  log_cmd [64];
    logic [7:0]  log_addr[64];
    logic [15:0] log_word[64];
    logic [31:0] log_blk [64];

    // bus environment: grants one cycle, records each transaction
    always @(negedge clk) begin
        if (mst_gnt) begin
            mst_gnt = 1'b0;
        end else if (mst_req && !hold) begin
            log_cmd[nlog]  = mst_cmd;
            log_addr[nlog] = mst_addr;
            log_word[nlog] = mst_word;
            log_blk[nlog]  = mst_block;
            nlog++;
            mst_shared = env_shared;
            mst_fill   = env_fill;
            mst_gnt    = 1'b1;
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            summary();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cpu_access(input logic we, input logic [7:0] a, input logic [15:0] d,
                              output logic [15:0] rd);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        do @(negedge clk); while (!cpu_ack);
        rd = cpu_rdata;
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic snoop(input logic [1:0] c, input logic [7:0] a, input logic [15:0] w,
                         output logic sh, output logic sup, output logic [31:0] blk);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = c; snp_addr = a; snp_word = w;
        #(P/4);
        sh = snp_shared; sup = snp_supply; blk = snp_block;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic chk_txn(input string req, input int k, input logic [1:0] c,
                           input logic [7:0] a, input logic [31:0] data);
        chk(req, {30'd0, log_cmd[k]}, {30'd0, c});
        chk(req, {24'd0, log_addr[k]}, {24'd0, a});
        if (c == 2'd1) chk(req, {16'd0, log_word[k]}, {16'd0, data[15:0]});
        if (c == 2'd2) chk(req, log_blk[k], data);
    endtask

    logic [15:0] rd;
    logic        sh, sup;
    logic [31:0] blk;
    int          base;

    task automatic t_reset();
        chk("R1 ack", {31'd0, cpu_ack}, 32'd0);
        chk("R1 req", {31'd0, mst_req}, 32'd0);
        snoop(2'd0, 8'h08, 16'h0, sh, sup, blk);
        chk("R1 shared", {31'd0, sh}, 32'd0);
        chk("R1 supply", {31'd0, sup}, 32'd0);
    endtask

    task automatic t_read_miss();
        env_shared = 1'b0; env_fill = 32'hBBBB_AAAA; base = nlog;
        cpu_access(1'b0, 8'h08, 16'h0, rd);
        chk("R2 count", nlog - base, 1);
        chk_txn("R2 txn", base, 2'd0, 8'h08, 32'h0);
        chk("R2 data", {16'd0, rd}, 32'h0000_AAAA);
        base = nlog;
        cpu_access(1'b0, 8'h09, 16'h0, rd);
        chk("R3 nobus", nlog - base, 0);
        chk("R3 data", {16'd0, rd}, 32'h0000_BBBB);
    endtask

    task automatic t_write_hits();
        base = nlog;
        cpu_access(1'b1, 8'h09, 16'h1111, rd);
        cpu_access(1'b1, 8'h09, 16'h1212, rd);
        chk("R4 nobus", nlog - base, 0);
        cpu_access(1'b0, 8'h09, 16'h0, rd);
        chk("R4 data", {16'd0, rd}, 32'h0000_1212);
    endtask

    task automatic t_snoop_read();
        snoop(2'd0, 8'h08, 16'h0, sh, sup, blk);
        chk("R8 shared", {31'd0, sh}, 32'd1);
        chk("R8 supply", {31'd0, sup}, 32'd1);
        chk("R8 block", blk, 32'h1212_AAAA);
    endtask

    task automatic t_upd_hold();
        env_shared = 1'b1; hold = 1'b1; base = nlog;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 8'h08; cpu_wdata = 16'h2222;
        repeat (3) @(negedge clk);
        snoop(2'd0, 8'h08, 16'h0, sh, sup, blk);
        chk("R6 old block", blk, 32'h1212_AAAA);
        chk("R6 ack", {31'd0, cpu_ack}, 32'd0);
        hold = 1'b0;
        do @(negedge clk); while (!cpu_ack);
        cpu_req = 1'b0; cpu_we = 1'b0;
        chk("R5 count", nlog - base, 1);
        chk_txn("R5 upd", base, 2'd1, 8'h08, 32'h2222);
        cpu_access(1'b0, 8'h08, 16'h0, rd);
        chk("R5 data", {16'd0, rd}, 32'h0000_2222);
    endtask

    task automatic t_upd_private();
        env_shared = 1'b0; base = nlog;
        cpu_access(1'b1, 8'h08, 16'h3333, rd);
        chk("R5 upd private", nlog - base, 1);
        base = nlog;
        cpu_access(1'b1, 8'h09, 16'h4444, rd);
        chk("R5 now modified", nlog - base, 0);
    endtask

    task automatic t_snoop_update();
        snoop(2'd1, 8'h09, 16'h5555, sh, sup, blk);
        chk("R9 shared", {31'd0, sh}, 32'd1);
        chk("R9 supply", {31'd0, sup}, 32'd0);
        base = nlog;
        cpu_access(1'b0, 8'h09, 16'h0, rd);
        chk("R9 word", {16'd0, rd}, 32'h0000_5555);
        env_shared = 1'b1;
        cpu_access(1'b1, 8'h08, 16'h6666, rd);
        chk("R9 shared-clean update", nlog - base, 1);
    endtask

    task automatic t_snoop_miss();
        snoop(2'd1, 8'h19, 16'h7777, sh, sup, blk);
        chk("R10 shared", {31'd0, sh}, 32'd0);
        snoop(2'd0, 8'h18, 16'h0, sh, sup, blk);
        chk("R10 supply", {31'd0, sup}, 32'd0);
        base = nlog;
        cpu_access(1'b0, 8'h09, 16'h0, rd);
        chk("R10 word kept", {16'd0, rd}, 32'h0000_5555);
        chk("R10 hit", nlog - base, 0);
    endtask

    task automatic t_replace();
        env_shared = 1'b0; env_fill = 32'hCCCC_DDDD; base = nlog;
        cpu_access(1'b0, 8'h10, 16'h0, rd);
        chk("R11 count", nlog - base, 2);
        chk_txn("R11 wb", base, 2'd2, 8'h08, 32'h5555_6666);
        chk_txn("R11 rd", base + 1, 2'd0, 8'h10, 32'h0);
        chk("R11 data", {16'd0, rd}, 32'h0000_DDDD);
        env_fill = 32'hEEEE_FFFF; base = nlog;
        cpu_access(1'b0, 8'h18, 16'h0, rd);
        chk("R11 clean victim", nlog - base, 1);
        chk("R11 data2", {16'd0, rd}, 32'h0000_FFFF);
    endtask

    task automatic t_write_miss();
        env_shared = 1'b1; env_fill = 32'h0B0B_0A0A; base = nlog;
        cpu_access(1'b1, 8'h0A, 16'h1234, rd);
        chk("R7 count shared", nlog - base, 2);
        chk_txn("R7 rd", base, 2'd0, 8'h0A, 32'h0);
        chk_txn("R7 upd", base + 1, 2'd1, 8'h0A, 32'h1234);
        snoop(2'd0, 8'h0A, 16'h0, sh, sup, blk);
        chk("R7 owner supply", {31'd0, sup}, 32'd1);
        chk("R7 block", blk, 32'h0B0B_1234);
        env_shared = 1'b0; env_fill = 32'h0D0D_0C0C; base = nlog;
        cpu_access(1'b1, 8'h0D, 16'h4321, rd);
        chk("R7 count private", nlog - base, 1);
        chk_txn("R7 rd2", base, 2'd0, 8'h0C, 32'h0);
        base = nlog;
        cpu_access(1'b0, 8'h0D, 16'h0, rd);
        chk("R7 merged", {16'd0, rd}, 32'h0000_4321);
        cpu_access(1'b1, 8'h0C, 16'h9999, rd);
        chk("R7 modified", nlog - base, 0);
    endtask

    task automatic t_snoop_block();
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = 2'd0; snp_addr = 8'h1E; snp_word = '0;
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h0C;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R12 stalled", {31'd0, cpu_ack}, 32'd0);
        end
        snp_valid = 1'b0;
        do @(negedge clk); while (!cpu_ack);
        chk("R12 data", {16'd0, cpu_rdata}, 32'h0000_9999);
        cpu_req = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        snp_valid = 1'b0; snp_cmd = 2'd3; snp_addr = '0; snp_word = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read_miss();
        t_write_hits();
        t_snoop_read();
        t_upd_hold();
        t_upd_private();
        t_snoop_update();
        t_snoop_miss();
        t_replace();
        t_write_miss();
        t_snoop_block();
        repeat (2) @(negedge clk);
        summary();
    end

endmodule